// File: doc/BRIEF.md
# Pulsed Amplitude Burst Sequencer

This block sets the level of a tone generator during burst testing. It alternates between two amplitude codes, a high level held for a programmed number of milliseconds and a low level held for a second programmed number of milliseconds. The cycle repeats until new settings are loaded. Amplitude codes are attenuation values in whole decibels: 0 is full scale, 98 is the quietest audible step, and 99 means silence. Both channels follow the same sequence. Each channel can be muted on its own.

An external millisecond strobe paces the sequencer. The tone datapath supplies the sign of each generated sample and the current tone frequency in hertz. When a level change falls due, the change is held back until the next sign change of the waveform, so the step lands at a zero crossing and causes no click. At tone frequencies below 500 Hz, waiting for a crossing would add a large delay. In that range the change is applied on the strobe at which the phase timer expires. A status output tells the display which of the two phases is active.

Top module: `burst_seq`

## Requirements
- R1: After reset the sequencer is in the high phase (`phase_on`=1) with the defaults loaded: high code 0, low code 30, high time 100 ms, low time 900 ms.
- R2: `amp_code` equals the high code while `phase_on` is 1 and the low code while `phase_on` is 0. It changes only when the phase changes or when settings are loaded.
- R3: A phase lasts a set number of `ms_tick` strobes, counted from the cycle in which the level actually switched. The timer expires on the strobe that brings the count to the programmed time. A strobe that arrives in the same cycle as a switch is not counted.
- R4: At or above the threshold frequency, an expired phase is held until the first zero crossing that follows. Strobes that arrive during this wait are not counted.
- R5: Below the threshold frequency (500 Hz), the phase changes on the clock edge of the expiring strobe, with no zero crossing needed.
- R6: If either programmed time is 0, the phase never changes. With high time 0 and low time nonzero, the low code is held. In every other case that contains a zero, the high code is held.
- R7: A `cfg_load` pulse takes in all four settings and restarts the sequence: the timer is cleared, any pending switch is dropped, and the next edge enters the high phase (or the low phase under R6).
- R8: Without new settings, the phases keep alternating between high and low indefinitely.
- R9: A muted channel outputs code 99 (silence). An unmuted channel outputs `amp_code`, so both channels are equal when their mute inputs are equal.
- R10: A zero crossing is a change of `smp_neg` between two consecutive samples that have `smp_valid` high. The first valid sample after reset never counts as a crossing. Values of `smp_neg` with `smp_valid` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| smp_valid | input | 1 | A new waveform sample is present |
| smp_neg | input | 1 | Sign of that sample (1 = negative) |
| freq_hz | input | 17 | Current tone frequency in Hz |
| cfg_load | input | 1 | Load the settings below and restart |
| on_ms | input | 10 | High-phase time, 0 to 999 ms |
| off_ms | input | 14 | Low-phase time, 0 to 9999 ms |
| amp_on | input | 7 | High-phase attenuation code |
| amp_off | input | 7 | Low-phase attenuation code |
| mute_l | input | 1 | Silence the left channel |
| mute_r | input | 1 | Silence the right channel |
| amp_code | output | 7 | Active attenuation code |
| phase_on | output | 1 | 1 in the high phase, 0 in the low phase |
| amp_l | output | 7 | Left channel attenuation code |
| amp_r | output | 7 | Right channel attenuation code |

## Verification
The checker assumes a few things about the inputs. It assumes `cfg_load` is a single-cycle pulse. It assumes `freq_hz` is steady in the cycle before any phase change, since the zero-crossing gate check compares against the previous cycle's frequency. It also assumes `smp_valid` marks each sample exactly once. The stimulus changes frequency and settings only while no switch is pending, raises every strobe and sample for one cycle at a falling clock edge, and keeps programmed times small so that every phase boundary can be reached and observed.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int ON_W  = 10;
    localparam int OFF_W = 14;
    localparam int AMP_W = 7;
    localparam int TMR_W = (OFF_W > ON_W) ? OFF_W : ON_W;

    localparam logic [AMP_W-1:0] AMP_SILENT      = AMP_W'(99);
    localparam logic [AMP_W-1:0] AMP_ON_DEFAULT  = AMP_W'(0);
    localparam logic [AMP_W-1:0] AMP_OFF_DEFAULT = AMP_W'(30);
    localparam logic [ON_W-1:0]  ON_MS_DEFAULT   = ON_W'(100);
    localparam logic [OFF_W-1:0] OFF_MS_DEFAULT  = OFF_W'(900);

    typedef enum logic {
        PH_OFF = 1'b0,
        PH_ON  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [ON_W-1:0]  on_ms;
        logic [OFF_W-1:0] off_ms;
        logic [AMP_W-1:0] amp_on;
        logic [AMP_W-1:0] amp_off;
    } burst_cfg_t;

    function automatic burst_cfg_t default_cfg();
        burst_cfg_t c;
        c.on_ms   = ON_MS_DEFAULT;
        c.off_ms  = OFF_MS_DEFAULT;
        c.amp_on  = AMP_ON_DEFAULT;
        c.amp_off = AMP_OFF_DEFAULT;
        return c;
    endfunction

    // A zero-length phase freezes the sequencer; a zero high time means
    // the low level is the one held.
    function automatic phase_e entry_phase(burst_cfg_t c);
        return (c.on_ms == '0 && c.off_ms != '0) ? PH_OFF : PH_ON;
    endfunction

    function automatic logic can_toggle(burst_cfg_t c);
        return (c.on_ms != '0) && (c.off_ms != '0);
    endfunction

    function automatic logic [TMR_W-1:0] phase_len(burst_cfg_t c, phase_e p);
        return (p == PH_ON) ? TMR_W'(c.on_ms) : TMR_W'(c.off_ms);
    endfunction

endpackage

// File: rtl/burst_zc_detect.sv
module burst_zc_detect (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic smp_neg,
    output logic zc
);
    logic prev_neg_q;
    logic have_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_neg_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (smp_valid) begin
            prev_neg_q  <= smp_neg;
            have_prev_q <= 1'b1;
        end
    end

    assign zc = smp_valid && have_prev_q && (smp_neg != prev_neg_q);
endmodule

// File: rtl/burst_phase_timer.sv
module burst_phase_timer #(
    parameter int TW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic          hold,
    input  logic [TW-1:0] dur,
    output logic          expire
);
    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + (TW+1)'(1);
    assign expire   = tick && !hold && (dur != '0) && (cnt_next == {1'b0, dur});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick && !hold && cnt_q != dur) begin
            cnt_q <= cnt_next[TW-1:0];
        end
    end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  burst_cfg_t        new_cfg,
    input  logic              expire,
    input  logic              zc,
    input  logic              low_freq,
    output phase_e            phase,
    output burst_cfg_t        cfg,
    output logic [TW-1:0]     cur_dur,
    output logic              hold,
    output logic              go
);
    phase_e     phase_q;
    burst_cfg_t cfg_q;
    logic       pending_q;

    assign cur_dur = TW'(phase_len(cfg_q, phase_q));
    assign hold    = pending_q || !can_toggle(cfg_q);
    assign go      = (pending_q || expire) && (low_freq || zc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= default_cfg();
            phase_q   <= PH_ON;
            pending_q <= 1'b0;
        end else if (load) begin
            cfg_q     <= new_cfg;
            phase_q   <= entry_phase(new_cfg);
            pending_q <= 1'b0;
        end else if (go) begin
            phase_q   <= (phase_q == PH_ON) ? PH_OFF : PH_ON;
            pending_q <= 1'b0;
        end else if (expire) begin
            pending_q <= 1'b1;
        end
    end

    assign phase = phase_q;
    assign cfg   = cfg_q;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int FREQ_W      = 17,
    parameter int LOW_FREQ_HZ = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              smp_valid,
    input  logic              smp_neg,
    input  logic [FREQ_W-1:0] freq_hz,
    input  logic              cfg_load,
    input  logic [ON_W-1:0]   on_ms,
    input  logic [OFF_W-1:0]  off_ms,
    input  logic [AMP_W-1:0]  amp_on,
    input  logic [AMP_W-1:0]  amp_off,
    input  logic              mute_l,
    input  logic              mute_r,
    output logic [AMP_W-1:0]  amp_code,
    output logic              phase_on,
    output logic [AMP_W-1:0]  amp_l,
    output logic [AMP_W-1:0]  amp_r
);
    localparam logic [FREQ_W-1:0] LOW_LIMIT = FREQ_W'(LOW_FREQ_HZ);

    burst_cfg_t       new_cfg;
    burst_cfg_t       cfg;
    phase_e           phase;
    logic [TMR_W-1:0] cur_dur;
    logic             hold, go, expire, zc, low_freq;

    assign new_cfg  = '{on_ms: on_ms, off_ms: off_ms, amp_on: amp_on, amp_off: amp_off};
    assign low_freq = freq_hz < LOW_LIMIT;

    burst_zc_detect zc_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_neg   (smp_neg),
        .zc        (zc)
    );

    burst_phase_timer #(.TW(TMR_W)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (cfg_load || go),
        .tick   (ms_tick),
        .hold   (hold),
        .dur    (cur_dur),
        .expire (expire)
    );

    burst_ctrl #(.TW(TMR_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .new_cfg  (new_cfg),
        .expire   (expire),
        .zc       (zc),
        .low_freq (low_freq),
        .phase    (phase),
        .cfg      (cfg),
        .cur_dur  (cur_dur),
        .hold     (hold),
        .go       (go)
    );

    assign phase_on = (phase == PH_ON);
    assign amp_code = phase_on ? cfg.amp_on : cfg.amp_off;

    generate
        for (genvar ch = 0; ch < 2; ch++) begin : g_chan
            logic             mute_c;
            logic [AMP_W-1:0] lvl_c;
            assign mute_c = (ch == 0) ? mute_l : mute_r;
            assign lvl_c  = mute_c ? AMP_SILENT : amp_code;
            if (ch == 0) begin : g_left
                assign amp_l = lvl_c;
            end else begin : g_right
                assign amp_r = lvl_c;
            end
        end
    endgenerate
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
    import burst_pkg::*;
#(
    parameter int FREQ_W      = 17,
    parameter int LOW_FREQ_HZ = 500
) (
    input logic              clk,
    input logic              rst,
    input logic              ms_tick,
    input logic              smp_valid,
    input logic              smp_neg,
    input logic [FREQ_W-1:0] freq_hz,
    input logic              cfg_load,
    input logic [ON_W-1:0]   on_ms,
    input logic [OFF_W-1:0]  off_ms,
    input logic [AMP_W-1:0]  amp_on,
    input logic [AMP_W-1:0]  amp_off,
    input logic              mute_l,
    input logic              mute_r,
    input logic [AMP_W-1:0]  amp_code,
    input logic              phase_on,
    input logic [AMP_W-1:0]  amp_l,
    input logic [AMP_W-1:0]  amp_r
);
    logic sgn_q, seen_q, frozen_q, zc_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            sgn_q    <= 1'b0;
            seen_q   <= 1'b0;
            frozen_q <= 1'b0;
        end else begin
            if (smp_valid) begin
                sgn_q  <= smp_neg;
                seen_q <= 1'b1;
            end
            if (cfg_load) frozen_q <= (on_ms == '0) || (off_ms == '0);
        end
    end

    assign zc_c = smp_valid && seen_q && (smp_neg != sgn_q);

    AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_load) && $stable(phase_on)) |-> $stable(amp_code));          // R2

    AST_ZC_GATED: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_load) && !$stable(phase_on) && ($past(freq_hz) >= FREQ_W'(LOW_FREQ_HZ)))
        |-> $past(zc_c));                                                        // R4

    AST_ZERO_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && !cfg_load) |=> $stable(phase_on));                          // R6

    AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && on_ms != '0) |=> phase_on);                                 // R7

    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && on_ms == '0 && off_ms != '0) |=> !phase_on);                // R7

    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mute_l || mute_r) |-> ((mute_l ? amp_l : amp_r) == AMP_SILENT));        // R9

    AST_CHAN_MATCH: assert property (@(posedge clk) disable iff (rst)
        (mute_l == mute_r) |-> (amp_l == amp_r));                                // R9
endmodule

bind burst_seq burst_seq_chk #(.FREQ_W(FREQ_W), .LOW_FREQ_HZ(LOW_FREQ_HZ)) chk_i (.*);

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;
    import burst_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ms_tick = 1'b0;
    logic              smp_valid = 1'b0;
    logic              smp_neg = 1'b0;
    logic [16:0]       freq_hz = 17'd100;
    logic              cfg_load = 1'b0;
    logic [ON_W-1:0]   on_ms = '0;
    logic [OFF_W-1:0]  off_ms = '0;
    logic [AMP_W-1:0]  amp_on = '0;
    logic [AMP_W-1:0]  amp_off = '0;
    logic              mute_l = 1'b0;
    logic              mute_r = 1'b0;
    logic [AMP_W-1:0]  amp_code, amp_l, amp_r;
    logic              phase_on;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    burst_seq dut_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .smp_valid(smp_valid),
        .smp_neg(smp_neg), .freq_hz(freq_hz), .cfg_load(cfg_load),
        .on_ms(on_ms), .off_ms(off_ms), .amp_on(amp_on), .amp_off(amp_off),
        .mute_l(mute_l), .mute_r(mute_r), .amp_code(amp_code),
        .phase_on(phase_on), .amp_l(amp_l), .amp_r(amp_r)
    );

    typedef struct packed {
        int on_t;
        int off_t;
        int a_hi;
        int a_lo;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{1, 1, 3, 40},
        '{2, 5, 0, 99},
        '{5, 2, 12, 20},
        '{3, 3, 98, 1},
        '{4, 1, 6, 60}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic sample(input logic neg);
        @(negedge clk) begin smp_valid = 1'b1; smp_neg = neg; end
        @(negedge clk) smp_valid = 1'b0;
    endtask

    task automatic load(input int t_on, input int t_off, input int a_hi, input int a_lo);
        @(negedge clk);
        on_ms = ON_W'(t_on); off_ms = OFF_W'(t_off);
        amp_on = AMP_W'(a_hi); amp_off = AMP_W'(a_lo);
        cfg_load = 1'b1;
        @(negedge clk) cfg_load = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset defaults
        chk("R1 phase after reset", int'(phase_on), 1);
        chk("R1 code after reset", int'(amp_code), 0);
        ticks(99);
        chk("R1 default high time not yet over", int'(phase_on), 1);
        ticks(1);
        chk("R1 default switch at 100 ms", int'(phase_on), 0);
        chk("R2 default low code", int'(amp_code), 30);
        ticks(899);
        chk("R3 default low time not yet over", int'(phase_on), 0);
        ticks(1);
        chk("R8 back to high after 900 ms", int'(phase_on), 1);

        // Vector table, low frequency: R3, R5, R7, R8
        foreach (VEC[k]) begin
            load(VEC[k].on_t, VEC[k].off_t, VEC[k].a_hi, VEC[k].a_lo);
            chk("R7 load enters high", int'(phase_on), 1);
            chk("R2 high code", int'(amp_code), VEC[k].a_hi);
            ticks(VEC[k].on_t - 1);
            chk("R3 high held before expiry", int'(phase_on), 1);
            ticks(1);
            chk("R5 immediate switch to low", int'(phase_on), 0);
            chk("R2 low code", int'(amp_code), VEC[k].a_lo);
            ticks(VEC[k].off_t - 1);
            chk("R3 low held before expiry", int'(phase_on), 0);
            ticks(1);
            chk("R8 return to high", int'(phase_on), 1);
            chk("R2 high code again", int'(amp_code), VEC[k].a_hi);
        end

        // R9: per-channel mute
        mute_l = 1'b1;
        @(negedge clk);
        chk("R9 muted left silent", int'(amp_l), 99);
        chk("R9 unmuted right follows", int'(amp_r), int'(amp_code));
        mute_l = 1'b0; mute_r = 1'b1;
        @(negedge clk);
        chk("R9 muted right silent", int'(amp_r), 99);
        chk("R9 unmuted left follows", int'(amp_l), int'(amp_code));
        mute_r = 1'b0;

        // R4: zero-crossing gating at 1 kHz
        freq_hz = 17'd1000;
        load(2, 3, 5, 25);
        sample(1'b0);
        ticks(2);
        chk("R4 expired but waiting", int'(phase_on), 1);
        ticks(5);
        sample(1'b0);
        chk("R4 no sign change no switch", int'(phase_on), 1);
        sample(1'b1);
        chk("R4 switch at crossing", int'(phase_on), 0);
        chk("R4 low code after crossing", int'(amp_code), 25);
        ticks(2);
        sample(1'b0);
        chk("R3 crossing before expiry ignored", int'(phase_on), 0);
        ticks(1);
        chk("R4 low held while pending", int'(phase_on), 0);
        sample(1'b1);
        chk("R4 return to high at crossing", int'(phase_on), 1);

        // R10: first valid sample after reset and invalid samples
        do_reset();
        freq_hz = 17'd2000;
        load(1, 1, 2, 44);
        ticks(1);
        sample(1'b1);
        chk("R10 first sample is not a crossing", int'(phase_on), 1);
        @(negedge clk) smp_neg = 1'b0;
        @(negedge clk) smp_neg = 1'b1;
        @(negedge clk) smp_neg = 1'b0;
        @(negedge clk);
        chk("R10 invalid samples ignored", int'(phase_on), 1);
        sample(1'b1);
        chk("R10 same sign no crossing", int'(phase_on), 1);
        sample(1'b0);
        chk("R10 valid sign change switches", int'(phase_on), 0);

        // R6: zero-length phases
        freq_hz = 17'd100;
        load(0, 5, 10, 70);
        chk("R6 zero high time enters low", int'(phase_on), 0);
        ticks(12);
        chk("R6 low held", int'(amp_code), 70);
        load(4, 0, 11, 71);
        chk("R6 zero low time enters high", int'(phase_on), 1);
        ticks(10);
        chk("R6 high held", int'(amp_code), 11);
        load(0, 0, 13, 72);
        ticks(3);
        chk("R6 both zero hold high", int'(amp_code), 13);

        // R7: reload mid-phase restarts timing
        load(3, 2, 1, 2);
        ticks(2);
        load(3, 2, 8, 9);
        ticks(2);
        chk("R7 reload restarted timer", int'(phase_on), 1);
        ticks(1);
        chk("R7 switch after full time", int'(amp_code), 9);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule